// File: doc/BRIEF.md
# Computer-Operating-Properly Watchdog with Shared Prescaler

This block watches for software that has stopped running normally. A free-running prescaler counts oscillator cycles. Each time it rolls over from all ones, it produces one tick, and each tick advances a small watchdog counter. If software does not service the block in time, the watchdog counter overflows. The block then raises a one-cycle reset request toward the chip's reset sequencer.

Software services the block by writing to one fixed bus address. The data value is irrelevant. A service write zeroes the watchdog counter. It also zeroes the upper field of the prescaler, which restarts the time to the next tick. The lowest prescaler bits keep counting.

Two high-voltage detect inputs can disable the watchdog. Each one comes from a comparator on an external pin. When either is high, the disable takes effect combinationally: the watchdog counter is held at zero and no reset request is made. The prescaler runs on in all cases. Both counters are visible at the outputs.

Top module: `cop_watchdog`

## Requirements
- R1: While the synchronous active-high reset is applied, the prescaler, the watchdog counter and the reset request all read zero one clock later.
- R2: Outside a service write, the prescaler increments by one on every clock and wraps from all ones to zero.
- R3: A service write is a cycle with the write strobe high and the address equal to SVC_ADDR (default 16'hFFFF). A write to any other address changes nothing.
- R4: A service write zeroes the watchdog counter. It also zeroes prescaler bits CLR_LO through PRE_W-1 (defaults 5 through 12). Prescaler bits below CLR_LO take their normal incremented value.
- R5: A tick occurs in a cycle where the prescaler is all ones and no service write is present. Each tick advances the watchdog counter by one on that edge.
- R6: A tick that arrives while the watchdog counter is at its maximum value does two things. It raises the reset request for exactly one cycle after that edge, and it wraps the counter to zero.
- R7: While either high-voltage input is high, the watchdog counter is zero after each edge and no reset request is made. The prescaler is unaffected.
- R8: A service write in the same cycle as an overflowing tick wins. No reset request follows, and the watchdog counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high chip reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address |
| hv_rst_pin | input | 1 | High-voltage detect on the reset pin (disables the watchdog) |
| hv_irq_pin | input | 1 | High-voltage detect on the interrupt pin (disables the watchdog) |
| rst_req | output | 1 | One-cycle reset request on watchdog overflow |
| wd_count | output | WD_W | Watchdog counter state |
| pre_count | output | PRE_W | Prescaler counter state |

## Verification
Two functions can fall in the same cycle: a service write and the prescaler rollover tick that would overflow the watchdog. The bench runs the counters until the prescaler is all ones and the watchdog is at its maximum, and then issues the service write in exactly that cycle. The check is that no reset request appears on the next cycle, that the watchdog reads zero, and that the prescaler's upper field reads zero.

A second collision puts the disable inputs against the overflowing tick. Separately, the bench services the block at every prescaler phase of a reduced configuration. Every output is compared each cycle against a reference model built from the requirements.

// File: rtl/cop_pkg.sv
package cop_pkg;
  typedef struct packed {
    logic service;
    logic enable;
  } cop_ctl_t;
endpackage

// File: rtl/cop_decode.sv
module cop_decode
  import cop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1
) (
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              hv_rst_pin,
  input  logic              hv_irq_pin,
  output cop_ctl_t          ctl
);
  always_comb begin
    ctl.service = bus_we && (bus_addr == SVC_ADDR);
    ctl.enable  = !(hv_rst_pin || hv_irq_pin);
  end
endmodule

// File: rtl/cop_prescaler.sv
module cop_prescaler #(
  parameter int PRE_W  = 13,
  parameter int CLR_LO = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             service,
  output logic [PRE_W-1:0] count,
  output logic             tick
);
  logic [PRE_W-1:0] inc;
  logic [PRE_W-1:0] nxt;

  assign inc  = count + 1'b1;
  assign tick = (&count) && !service;

  for (genvar i = 0; i < PRE_W; i++) begin : g_bit
    if (i >= CLR_LO) begin : g_clr
      assign nxt[i] = service ? 1'b0 : inc[i];
    end else begin : g_keep
      assign nxt[i] = inc[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= nxt;
  end

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    !service |=> count == $past(count) + 1'b1);
  a_r4_pre_clear: assert property (@(posedge clk) disable iff (rst)
    service |=> count[PRE_W-1:CLR_LO] == '0);
endmodule

// File: rtl/cop_counter.sv
module cop_counter #(
  parameter int WD_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            service,
  input  logic            enable,
  output logic [WD_W-1:0] count,
  output logic            rst_req
);
  logic at_max;
  assign at_max = &count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      rst_req <= 1'b0;
    end else if (!enable || service) begin
      count   <= '0;
      rst_req <= 1'b0;
    end else if (tick) begin
      count   <= count + 1'b1;
      rst_req <= at_max;
    end else begin
      rst_req <= 1'b0;
    end
  end

  a_r6_single: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> count == '0);
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (count == '0) && !rst_req);
  a_r8_service_wins: assert property (@(posedge clk) disable iff (rst)
    service |=> (count == '0) && !rst_req);
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
  import cop_pkg::*;
#(
  parameter int PRE_W  = 13,
  parameter int CLR_LO = 5,
  parameter int WD_W   = 6,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              hv_rst_pin,
  input  logic              hv_irq_pin,
  output logic              rst_req,
  output logic [WD_W-1:0]   wd_count,
  output logic [PRE_W-1:0]  pre_count
);
  cop_ctl_t ctl;
  logic     tick;

  cop_decode #(.ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)) u_dec (
    .bus_we(bus_we), .bus_addr(bus_addr),
    .hv_rst_pin(hv_rst_pin), .hv_irq_pin(hv_irq_pin), .ctl(ctl));

  cop_prescaler #(.PRE_W(PRE_W), .CLR_LO(CLR_LO)) u_pre (
    .clk(clk), .rst(rst), .service(ctl.service),
    .count(pre_count), .tick(tick));

  cop_counter #(.WD_W(WD_W)) u_wd (
    .clk(clk), .rst(rst), .tick(tick), .service(ctl.service),
    .enable(ctl.enable), .count(wd_count), .rst_req(rst_req));

  a_r5_advance: assert property (@(posedge clk) disable iff (rst)
    (ctl.enable && !ctl.service && !(&pre_count)) |=> $stable(wd_count));
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (pre_count == '0) && (wd_count == '0) && !rst_req);
endmodule

// File: tb/sim_cop_watchdog.sv
module sim_cop_watchdog;
  localparam int PRE_W = 7, CLR_LO = 2, WD_W = 3, ADDR_W = 16;
  localparam int PMAX = (1 << PRE_W) - 1;
  localparam int WMAX = (1 << WD_W) - 1;
  localparam int LOMASK = (1 << CLR_LO) - 1;

  logic clk = 0, rst = 1, bus_we = 0, hv_r = 0, hv_i = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic rst_req;
  logic [WD_W-1:0] wd_count;
  logic [PRE_W-1:0] pre_count;

  int pre_m, wd_m, req_m, checks = 0, fails = 0;

  always #10 clk = ~clk;

  cop_watchdog #(.PRE_W(PRE_W), .CLR_LO(CLR_LO), .WD_W(WD_W),
                 .ADDR_W(ADDR_W), .SVC_ADDR(16'hFFFF)) u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .hv_rst_pin(hv_r), .hv_irq_pin(hv_i), .rst_req(rst_req),
    .wd_count(wd_count), .pre_count(pre_count));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk({tag, " prescaler (R2 R4)"}, int'(pre_count), pre_m);
    chk({tag, " watchdog (R5 R7)"}, int'(wd_count), wd_m);
    chk({tag, " request (R6 R8)"}, int'(rst_req), req_m);
  endtask

  // one cycle: drive at negedge, model the edge, compare at next negedge
  task automatic step(bit we, logic [ADDR_W-1:0] a, bit r, bit i, string tag);
    bit svc, en, tk;
    bus_we = we; bus_addr = a; hv_r = r; hv_i = i; rst = 0;
    svc = we && (a == 16'hFFFF);
    en  = !(r || i);
    tk  = (pre_m == PMAX) && !svc;
    req_m = (en && tk && !svc && wd_m == WMAX) ? 1 : 0;
    if (!en || svc) wd_m = 0;
    else if (tk)    wd_m = (wd_m + 1) & WMAX;
    pre_m = svc ? ((pre_m + 1) & LOMASK) : ((pre_m + 1) & PMAX);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    rst = 1; bus_we = 0; hv_r = 0; hv_i = 0;
    @(posedge clk); @(negedge clk);
    pre_m = 0; wd_m = 0; req_m = 0;
    compare("R1 reset");
    rst = 0;
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) step(0, 16'h0, 0, 0, tag);
  endtask

  initial begin
    #5_000_000;
    fails++; checks++;
    $display("FAIL watchdog timeout");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seen;
    @(negedge clk);
    do_reset();
    // R2 R5 R6: free run through two overflows, counting request pulses
    seen = 0;
    for (int k = 0; k < 2 * (PMAX + 1) * (WMAX + 1) + 4; k++) begin
      step(0, 16'h0, 0, 0, "R6 free run");
      seen += int'(rst_req);
    end
    chk("R6 pulse count", seen, 2);
    // R3: writes to other addresses have no effect
    do_reset();
    idle(300, "R3 pre");
    for (int k = 0; k < 40; k++) step(1, 16'hFFFE - 16'(k * 97), 0, 0, "R3 wrong addr");
    for (int k = 0; k < 20; k++) step(0, 16'hFFFF, 0, 0, "R3 no strobe");
    // R4: service at every prescaler phase
    for (int p = 0; p <= PMAX; p++) begin
      do_reset();
      idle(p + (PMAX + 1), "R4 lead");
      step(1, 16'hFFFF, 0, 0, "R4 service");
      chk("R4 low bits kept", int'(pre_count) & ~LOMASK, 0);
      idle(PMAX + 2, "R4 after");
    end
    // R8: service exactly in the overflowing tick cycle
    do_reset();
    while (!(pre_m == PMAX && wd_m == WMAX)) step(0, 16'h0, 0, 0, "R8 approach");
    step(1, 16'hFFFF, 0, 0, "R8 collide");
    chk("R8 no request", int'(rst_req), 0);
    chk("R8 wd zero", int'(wd_count), 0);
    idle(5, "R8 after");
    // R7: disable at the overflowing tick, via each pin
    for (int w = 0; w < 2; w++) begin
      do_reset();
      while (!(pre_m == PMAX && wd_m == WMAX)) step(0, 16'h0, 0, 0, "R7 approach");
      step(0, 16'h0, w == 0, w == 1, "R7 collide");
      chk("R7 no request", int'(rst_req), 0);
      for (int k = 0; k < 3 * (PMAX + 1); k++) step(0, 16'h0, w == 1, w == 0, "R7 held");
      chk("R7 wd held zero", int'(wd_count), 0);
      idle(2 * (PMAX + 1), "R7 release");
    end
    // R1: reset mid count
    idle(200, "R1 pre");
    do_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule